// File: doc/BRIEF.md
# Byte-Serial to Wide-Memory Read Bridge

This block connects a requester and a memory-style responder whose read protocols do not match. The requester has only a narrow address port. It sends a 16-bit address as two bytes. The low byte is qualified by a first request line and acknowledged by the bridge. The high byte is qualified by a second request line, and that line stays high until read data comes back with a valid flag. The responder needs the whole address at once, together with a read strobe, and it presents its data a fixed time after the strobe rises.

The bridge performs the reverse of each side's steps. It latches the low byte and acknowledges it. It then latches the high byte and raises the read strobe with the assembled address. It counts the access delay in clock cycles, captures the memory word, and returns it to the requester with a valid flag. Each acknowledge, strobe and valid signal is held until the requester lowers the request line it answers. The block handles one read at a time and is fully synchronous.

Top module: `rdx_read_bridge`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `host_lo_ack`, `mem_rd`, `host_data_vld`, `mem_addr` and `host_rdata` are all zero.
- R2: When the bridge is idle with `host_lo_ack` low and it samples `host_lo_req` high on a rising edge, it stores `host_abyte` as address bits 7:0 and drives `host_lo_ack` high from that edge onward.
- R3: On the rising edge after `host_lo_req` is sampled low, `host_lo_ack` is low.
- R4: Once the low byte has been taken, the first rising edge that samples `host_hi_req` high stores `host_abyte` as address bits 15:8. From that edge, `mem_rd` is high and `mem_addr` equals {high byte, low byte}.
- R5: `mem_rdata` is sampled on the LAT-th rising edge after the edge that raised `mem_rd`. Here LAT = ceil(ACCESS_NS / CLK_NS), with a minimum of 1; the default is 5. `host_data_vld` rises at that same edge, and `host_rdata` then carries the sampled word. `host_data_vld` is low during the earlier cycles.
- R6: While `mem_rd` stays high, `mem_addr` does not change. While `host_data_vld` stays high, `host_rdata` does not change.
- R7: When `host_hi_req` is sampled low while `host_data_vld` is high, `mem_rd` and `host_data_vld` are both low after that edge, and the bridge is idle again.
- R8: When the bridge is idle, `host_hi_req` has no effect: `mem_rd`, `host_data_vld` and `host_lo_ack` remain low.
- R9: A new read starts only after `host_lo_ack` has gone low. If `host_lo_req` is held high across the end of a read, no new read starts, even when `host_hi_req` is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_abyte | input | BYTE_W | Address byte from the requester |
| host_lo_req | input | 1 | Requester signals that the low address byte is valid |
| host_lo_ack | output | 1 | Bridge acknowledges the low address byte |
| host_hi_req | input | 1 | Requester signals that the high address byte is valid and asks for data |
| host_data_vld | output | 1 | Read data valid toward the requester |
| host_rdata | output | DATA_W | Read data toward the requester |
| mem_addr | output | 2*BYTE_W | Assembled address toward the memory |
| mem_rd | output | 1 | Read strobe toward the memory |
| mem_rdata | input | DATA_W | Data from the memory, valid LAT cycles after the strobe rises |

## Verification
The hardest point to observe from the ports is the edge on which the memory word is captured. A capture one cycle early looks the same as a correct one unless the responder returns wrong data before its delay has run out. The bench therefore models a responder that counts the cycles since the strobe rose and drives a cycle-dependent junk word until that count reaches LAT. Any capture on the wrong edge then produces a wrong word. The sweep also varies the gap between the two address bytes, whether the first request is held high, and how long the requester takes to release the data. These variations exercise the path where the acknowledge stays high past the end of a read.

// File: rtl/rdx_pkg.sv
// Shared definitions for the read bridge.
// Assumes: clock period and access time are given in whole nanoseconds.
package rdx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDRHI = 2'd1,
        ST_ACCESS = 2'd2,
        ST_RETURN = 2'd3
    } rdx_state_t;

    // Number of clock cycles that cover the access time, never below one.
    function automatic int access_cycles(input int access_ns, input int clk_ns);
        int c;
        c = (access_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/rdx_addr_hold.sv
// Holding registers for the two address bytes.
// Assumes: the load strobes come from the controller, one per byte.
module rdx_addr_hold #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   byte_in,
    input  logic                load_lo,
    input  logic                load_hi,
    output logic [2*BYTE_W-1:0] addr_out
);

    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    // Capture each address byte when its strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (load_lo) lo_q <= byte_in;
            if (load_hi) hi_q <= byte_in;
        end
    end

    assign addr_out = {hi_q, lo_q};

endmodule

// File: rtl/rdx_delay_timer.sv
// Down-counter that measures the memory access time.
// Assumes: start is a one-cycle pulse; run is high while waiting for data.
module rdx_delay_timer #(
    parameter int LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);

    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(LAT - 1);

    logic [CW-1:0] cnt_q;

    // Load on start, then count down to zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD_VAL;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/rdx_data_hold.sv
// Register that holds the memory word for the requester.
// Assumes: capture is a one-cycle pulse that arrives when memory data is valid.
module rdx_data_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // Keep the last captured word until the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (capture) dout <= din;
    end

endmodule

// File: rtl/rdx_ctrl_fsm.sv
// Sequencer for one bridged read: low-byte handshake, high-byte handshake,
// timed memory access, and data return.
// Assumes: request lines are synchronous to clk; one read in flight at a time.
module rdx_ctrl_fsm
    import rdx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lo_req,
    input  logic hi_req,
    input  logic timer_done,
    output logic lo_ack,
    output logic rd_strobe,
    output logic data_vld,
    output logic load_lo,
    output logic load_hi,
    output logic timer_start,
    output logic timer_run,
    output logic data_cap
);

    rdx_state_t state_q, state_d;

    logic begin_rd;

    // Start a read only with a fresh low-byte request.
    assign begin_rd = (state_q == ST_IDLE) && lo_req && !lo_ack;

    // Next-state and strobe decoding.
    always_comb begin
        state_d     = state_q;
        load_lo     = 1'b0;
        load_hi     = 1'b0;
        timer_start = 1'b0;
        timer_run   = 1'b0;
        data_cap    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (begin_rd) begin
                    load_lo = 1'b1;
                    state_d = ST_ADDRHI;
                end
            end
            ST_ADDRHI: begin
                if (hi_req) begin
                    load_hi     = 1'b1;
                    timer_start = 1'b1;
                    state_d     = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                timer_run = 1'b1;
                if (timer_done) begin
                    data_cap = 1'b1;
                    state_d  = ST_RETURN;
                end
            end
            ST_RETURN: begin
                if (!hi_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Low-byte acknowledge: set on acceptance, cleared once the request falls.
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_ack <= 1'b0;
        else if (!lo_req) lo_ack <= 1'b0;
        else if (begin_rd) lo_ack <= 1'b1;
    end

    // Memory strobe: raised with the high byte, held until data is released.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rd_strobe <= 1'b0;
        else if (load_hi)                          rd_strobe <= 1'b1;
        else if (state_q == ST_RETURN && !hi_req)  rd_strobe <= 1'b0;
    end

    // Data valid: raised on capture, dropped when the requester lets go.
    always_ff @(posedge clk) begin
        if (!rst_n)                                data_vld <= 1'b0;
        else if (data_cap)                         data_vld <= 1'b1;
        else if (state_q == ST_RETURN && !hi_req)  data_vld <= 1'b0;
    end

endmodule

// File: rtl/rdx_read_bridge.sv
// Top level: bridges a byte-serial two-handshake read request onto a
// wide-address memory read with a fixed access delay.
// Assumes: the memory returns data ACCESS_NS after the strobe rises and holds
// it while strobe and address stay steady.
module rdx_read_bridge #(
    parameter int BYTE_W    = 8,
    parameter int DATA_W    = 16,
    parameter int ACCESS_NS = 100,
    parameter int CLK_NS    = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   host_abyte,
    input  logic                host_lo_req,
    output logic                host_lo_ack,
    input  logic                host_hi_req,
    output logic                host_data_vld,
    output logic [DATA_W-1:0]   host_rdata,
    output logic [2*BYTE_W-1:0] mem_addr,
    output logic                mem_rd,
    input  logic [DATA_W-1:0]   mem_rdata
);

    localparam int LAT = rdx_pkg::access_cycles(ACCESS_NS, CLK_NS);

    logic load_lo, load_hi, timer_start, timer_run, timer_done, data_cap;

    rdx_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lo_req      (host_lo_req),
        .hi_req      (host_hi_req),
        .timer_done  (timer_done),
        .lo_ack      (host_lo_ack),
        .rd_strobe   (mem_rd),
        .data_vld    (host_data_vld),
        .load_lo     (load_lo),
        .load_hi     (load_hi),
        .timer_start (timer_start),
        .timer_run   (timer_run),
        .data_cap    (data_cap)
    );

    rdx_addr_hold #(.BYTE_W(BYTE_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (host_abyte),
        .load_lo  (load_lo),
        .load_hi  (load_hi),
        .addr_out (mem_addr)
    );

    rdx_delay_timer #(.LAT(LAT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (timer_start),
        .run   (timer_run),
        .done  (timer_done)
    );

    rdx_data_hold #(.DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (data_cap),
        .din     (mem_rdata),
        .dout    (host_rdata)
    );

endmodule

// File: rtl/rdx_read_bridge_chk.sv
// Port-level protocol checker for rdx_read_bridge, attached with bind.
// Assumes: the same parameters as the bridge instance it watches.
module rdx_read_bridge_chk #(
    parameter int BYTE_W    = 8,
    parameter int DATA_W    = 16,
    parameter int ACCESS_NS = 100,
    parameter int CLK_NS    = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_lo_req,
    input logic                host_lo_ack,
    input logic                host_hi_req,
    input logic                host_data_vld,
    input logic [DATA_W-1:0]   host_rdata,
    input logic [2*BYTE_W-1:0] mem_addr,
    input logic                mem_rd
);

    localparam int LAT = rdx_pkg::access_cycles(ACCESS_NS, CLK_NS);

    logic [15:0] rd_cycles;

    // Count cycles of strobe high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_cycles <= '0;
        else if (!mem_rd)           rd_cycles <= '0;
        else if (rd_cycles != '1)   rd_cycles <= rd_cycles + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!host_lo_ack && !mem_rd && !host_data_vld));

    p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_lo_ack) |-> $past(host_lo_req));

    p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !host_lo_req |=> !host_lo_ack);

    p_rd_after_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> $past(host_hi_req));

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_data_vld) |-> (rd_cycles == 16'(LAT)));

    p_vld_within_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_vld |-> mem_rd);

    p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> $stable(mem_addr));

    p_rdata_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_vld && $past(host_data_vld)) |-> $stable(host_rdata));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_vld && !host_hi_req) |=> (!host_data_vld && !mem_rd));

endmodule

bind rdx_read_bridge rdx_read_bridge_chk #(
    .BYTE_W    (BYTE_W),
    .DATA_W    (DATA_W),
    .ACCESS_NS (ACCESS_NS),
    .CLK_NS    (CLK_NS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_lo_req   (host_lo_req),
    .host_lo_ack   (host_lo_ack),
    .host_hi_req   (host_hi_req),
    .host_data_vld (host_data_vld),
    .host_rdata    (host_rdata),
    .mem_addr      (mem_addr),
    .mem_rd        (mem_rd)
);

// File: tb/sim_rdx_read_bridge.sv
module sim_rdx_read_bridge;

    localparam int LAT = (100 + 20 - 1) / 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_abyte = '0;
    logic        host_lo_req = 1'b0;
    logic        host_hi_req = 1'b0;
    logic        host_lo_ack, host_data_vld, mem_rd;
    logic [15:0] host_rdata, mem_addr;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;

    always #10 clk = ~clk;

    rdx_read_bridge u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_abyte    (host_abyte),
        .host_lo_req   (host_lo_req),
        .host_lo_ack   (host_lo_ack),
        .host_hi_req   (host_hi_req),
        .host_data_vld (host_data_vld),
        .host_rdata    (host_rdata),
        .mem_addr      (mem_addr),
        .mem_rd        (mem_rd),
        .mem_rdata     (mem_rdata)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    // Responder: junk until LAT cycles after the strobe rose, then the word.
    always @(negedge clk) begin
        if (mem_rd) rd_cnt = rd_cnt + 1;
        else        rd_cnt = 0;
        mem_rdata = (rd_cnt >= LAT) ? mem_word(mem_addr) : (16'hDEAD ^ 16'(rd_cnt));
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_read(input logic [15:0] a, input int gap,
                           input bit hold_lo, input int linger);
        @(negedge clk);
        host_abyte  = a[7:0];
        host_lo_req = 1'b1;
        @(negedge clk);
        chk(host_lo_ack == 1'b1, "R2 ack", 16'(host_lo_ack), 16'h1);
        if (!hold_lo) begin
            host_lo_req = 1'b0;
            @(negedge clk);
            chk(host_lo_ack == 1'b0, "R3 ack drop", 16'(host_lo_ack), 16'h0);
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(mem_rd == 1'b0, "R4 no early rd", 16'(mem_rd), 16'h0);
        end
        host_abyte  = a[15:8];
        host_hi_req = 1'b1;
        @(negedge clk);
        chk(mem_rd == 1'b1, "R4 rd", 16'(mem_rd), 16'h1);
        chk(mem_addr == a, "R4 addr", mem_addr, a);
        host_abyte = ~a[15:8];
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            chk(host_data_vld == 1'b0, "R5 early vld", 16'(host_data_vld), 16'h0);
        end
        @(negedge clk);
        chk(host_data_vld == 1'b1, "R5 vld", 16'(host_data_vld), 16'h1);
        chk(host_rdata == mem_word(a), "R5 data", host_rdata, mem_word(a));
        for (int l = 0; l < linger; l++) begin
            @(negedge clk);
            chk(host_rdata == mem_word(a), "R6 data steady", host_rdata, mem_word(a));
            chk(mem_addr == a, "R6 addr steady", mem_addr, a);
        end
        host_hi_req = 1'b0;
        host_lo_req = 1'b0;
        @(negedge clk);
        chk(!mem_rd && !host_data_vld, "R7 release",
            16'({mem_rd, host_data_vld}), 16'h0);
        chk(host_lo_ack == 1'b0, "R3 ack clear", 16'(host_lo_ack), 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!host_lo_ack && !mem_rd && !host_data_vld, "R1 outputs",
            16'({host_lo_ack, mem_rd, host_data_vld}), 16'h0);
        chk(mem_addr == 16'h0 && host_rdata == 16'h0, "R1 data", mem_addr | host_rdata, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!host_lo_ack && !mem_rd && !host_data_vld && mem_addr == 16'h0, "R1 after release",
            mem_addr, 16'h0);

        // R8: high request alone while idle does nothing.
        host_abyte  = 8'h77;
        host_hi_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!mem_rd && !host_data_vld && !host_lo_ack, "R8 idle hi_req",
                16'({mem_rd, host_data_vld, host_lo_ack}), 16'h0);
        end
        host_hi_req = 1'b0;

        // Sweep of addresses and handshake timings.
        do_read(16'h0000, 0, 1'b0, 0);
        do_read(16'hFFFF, 1, 1'b1, 2);
        for (int k = 0; k < 16; k++) begin
            logic [15:0] a;
            a = (16'h1 << k) ^ (16'(k) * 16'h1111);
            do_read(a, k % 3, k[0], k % 4);
        end

        // R9: low request held high across the end of a read.
        @(negedge clk);
        host_abyte  = 8'h34;
        host_lo_req = 1'b1;
        @(negedge clk);
        host_abyte  = 8'h12;
        host_hi_req = 1'b1;
        repeat (LAT + 1) @(negedge clk);
        chk(host_rdata == mem_word(16'h1234), "R9 first read", host_rdata, mem_word(16'h1234));
        host_hi_req = 1'b0;
        @(negedge clk);
        chk(host_lo_ack == 1'b1, "R9 ack held", 16'(host_lo_ack), 16'h1);
        host_hi_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(mem_rd == 1'b0, "R9 no restart", 16'(mem_rd), 16'h0);
        end
        host_hi_req = 1'b0;
        host_lo_req = 1'b0;
        @(negedge clk);
        chk(host_lo_ack == 1'b0, "R9 ack cleared", 16'(host_lo_ack), 16'h0);
        do_read(16'hA55A, 2, 1'b0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule